// File: doc/BRIEF.md
# Two-Channel Potentiometer Register Bank with I2C Slave Front End

This block is the control side of a two-channel, 128-step digital potentiometer. It is an I2C slave. It watches sampled SCL and SDA, spots START and STOP, and checks a device-select byte against three strap pins. It then takes one register-address byte and reads or writes data bytes. SDA is open drain, so the block only pulls the line low through an output enable.

Behind the bus sits a register file with two banks that share addresses 0 and 1. One bank is the volatile wiper bank that drives the outputs. The other is the retained start-up bank, which also holds six general-purpose bytes. A steering bit in the control register picks which bank an access reaches. A retained write is modelled as a busy period that starts at the STOP of the transaction. During that period a status bit reads high and every register write is dropped. The outputs are two 7-bit wiper codes and a shutdown level that combines a control bit with an active-low pin.

Top module: `pot_i2c_regbank`

## Requirements
- R1: After reset both wiper outputs are 64, shutdown is low when the pin is high, SDA is released, and the control register (address 8) reads 0x40.
- R2: The slave acknowledges a device byte only when its upper four bits are 1010 and the next three equal the strap pins, with bit 0 = 1 for read and 0 for write. After a non-matching byte it neither acknowledges nor acts until the next START.
- R3: The slave pulls SDA low during the ninth clock after a matching device byte, after the address byte, and after every written data byte, and it asserts the pull only while SCL is low.
- R4: With steering bit 7 of address 8 clear, a write to address 0 or 1 stores bits 6..0 in both the start-up register and the wiper of that channel, and a read returns {0, stored value}.
- R5: With steering bit 7 set, a write to address 0 or 1 changes only the wiper, and reads of 0 and 1 return the wiper. The start-up value stays as it was.
- R6: Addresses 2 to 7 hold general-purpose bytes reachable only with steering clear. With steering set they read 0x00, and written bytes are acknowledged but dropped.
- R7: Address 8 holds steering in bit 7, the shutdown-enable bit in bit 6 (active low, reset 1) and the read-only busy bit in bit 5. Bits 4..0 read 0.
- R8: The shutdown output is high when bit 6 of address 8 is 0 or the pin shdnPin is low.
- R9: A STOP that ends a transaction containing an accepted start-up-bank write raises the busy bit for exactly NV_BUSY_CYCLES clocks.
- R10: While busy, writes to addresses 0 to 8 are acknowledged but change no register.
- R11: The address does not advance. Consecutive data bytes of one write go to the same register, so the last byte is kept, and consecutive reads return the same byte.
- R12: A repeated START restarts device-byte matching. The latched address is kept, so a write-then-read sequence reads the addressed register, and a non-matching byte after the repeated START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line (bus level) |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| idPins | input | 3 | Strap pins compared with device-byte bits 3..1 |
| shdnPin | input | 1 | Active-low shutdown pin |
| wiper0 | output | 7 | Wiper code of channel 0 |
| wiper1 | output | 7 | Wiper code of channel 1 |
| shutdown | output | 1 | High when the potentiometer is shut down |

## Verification
The hardest state to reach from the pins is a write that arrives while the busy bit is still high. The bench widens the busy window with a parameter. It then starts a retained write and issues a full read of the control register followed by further writes before the window closes. It confirms the outcome only after the window ends, by reading registers back and watching the wiper outputs. Steering-dependent behaviour is checked by reading the same address with steering set and with steering cleared.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // strobes from the bus controller to the register datapath, one cycle wide
  typedef struct packed {
    logic       addrLoad;   // address byte received
    logic       dataWrite;  // write data byte received
    logic       stopSeen;   // STOP ended an active transaction
    logic [7:0] byteVal;    // byte carried by addrLoad / dataWrite
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_DEVID,
    BUS_REGADDR,
    BUS_WRDATA,
    BUS_RDDATA,
    BUS_IGNORE
  } busState_t;

endpackage

// File: rtl/pot_i2c_ctrl.sv
module pot_i2c_ctrl
  import pot_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  idPins,
  input  logic [7:0]  rdByte,
  output logic        sdaOe,
  output ctrlStrobe_t strobe,
  output logic        sclLevel
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclLevel = sclS;

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       isRead;
  logic       rxState;

  assign rxState = (state == BUS_DEVID) || (state == BUS_REGADDR) || (state == BUS_WRDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= BUS_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (startDet) begin
        state  <= BUS_DEVID;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        strobe.stopSeen <= (state != BUS_IDLE);
        state  <= BUS_IDLE;
        sdaOe  <= 1'b0;
      end else if (rxState) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) shReg <= {shReg[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall && bitCnt == 4'd8) begin
          case (state)
            BUS_DEVID: begin
              if (shReg[7:1] == {DEV_PREFIX, idPins}) begin
                sdaOe  <= 1'b1;
                isRead <= shReg[0];
              end else begin
                state <= BUS_IGNORE;
              end
            end
            BUS_REGADDR: begin
              sdaOe           <= 1'b1;
              strobe.addrLoad <= 1'b1;
              strobe.byteVal  <= shReg;
            end
            default: begin
              sdaOe            <= 1'b1;
              strobe.dataWrite <= 1'b1;
              strobe.byteVal   <= shReg;
            end
          endcase
        end else if (sclFall && bitCnt == 4'd9) begin
          bitCnt <= '0;
          sdaOe  <= 1'b0;
          case (state)
            BUS_DEVID: begin
              if (isRead) begin
                state <= BUS_RDDATA;
                shReg <= rdByte;
                sdaOe <= ~rdByte[7];
              end else begin
                state <= BUS_REGADDR;
              end
            end
            BUS_REGADDR: state <= BUS_WRDATA;
            default:     state <= BUS_WRDATA;
          endcase
        end
      end else if (state == BUS_RDDATA) begin
        if (sclRise) begin
          if (bitCnt == 4'd8 && sdaS) state <= BUS_IGNORE;  // master NACK
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            shReg  <= rdByte;
            sdaOe  <= ~rdByte[7];
          end else if (bitCnt == 4'd8) begin
            sdaOe <= 1'b0;
          end else if (bitCnt != 4'd0) begin
            shReg <= {shReg[6:0], 1'b0};
            sdaOe <= ~shReg[6];
          end
        end
      end
    end
  end

endmodule

// File: rtl/pot_reg_dp.sv
module pot_reg_dp
  import pot_i2c_pkg::*;
#(
  parameter int NUM_CH         = 2,
  parameter int GP_COUNT       = 6,
  parameter int WIPER_W        = 7,
  parameter int NV_BUSY_CYCLES = 400
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic                      shdnPin,
  output logic [7:0]                rdByte,
  output logic [NUM_CH-1:0][WIPER_W-1:0] wiperOut,
  output logic                      shutdown,
  output logic                      nvBusy
);

  localparam int ACR_ADDR = NUM_CH + GP_COUNT;
  localparam int CNT_W    = $clog2(NV_BUSY_CYCLES + 1);
  localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);

  logic [7:0]  regAddr;
  logic        volSel, shdnBit, nvPending;
  logic [CNT_W-1:0] busyCnt;
  logic        writeOk;
  logic [NUM_CH-1:0] chanHit;
  logic [GP_COUNT-1:0] gpHit;
  logic        acrHit;
  logic [NUM_CH-1:0][WIPER_W-1:0] ivrReg;
  logic [GP_COUNT-1:0][7:0] gpReg;

  assign writeOk = strobe.dataWrite & ~nvBusy;
  assign acrHit  = (regAddr == 8'(ACR_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regAddr <= '0;
    else if (strobe.addrLoad) regAddr <= strobe.byteVal;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanHit[c] = (regAddr == 8'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ivrReg[c]   <= MID_CODE;
        wiperOut[c] <= MID_CODE;
      end else if (writeOk && chanHit[c]) begin
        wiperOut[c] <= strobe.byteVal[WIPER_W-1:0];
        if (!volSel) ivrReg[c] <= strobe.byteVal[WIPER_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
    assign gpHit[g] = (regAddr == 8'(NUM_CH + g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gpReg[g] <= '0;
      else if (writeOk && gpHit[g] && !volSel) gpReg[g] <= strobe.byteVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volSel    <= 1'b0;
      shdnBit   <= 1'b1;
      nvPending <= 1'b0;
      nvBusy    <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (writeOk && acrHit) begin
        volSel  <= strobe.byteVal[7];
        shdnBit <= strobe.byteVal[6];
      end
      if (strobe.stopSeen) begin
        nvPending <= 1'b0;
        if (nvPending) begin
          nvBusy  <= 1'b1;
          busyCnt <= CNT_W'(NV_BUSY_CYCLES - 1);
        end
      end else if (writeOk && !volSel && (|chanHit || |gpHit)) begin
        nvPending <= 1'b1;
      end
      if (nvBusy) begin
        if (busyCnt == '0) nvBusy <= 1'b0;
        else busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    for (int c = 0; c < NUM_CH; c++)
      if (chanHit[c]) rdByte = 8'(volSel ? wiperOut[c] : ivrReg[c]);
    for (int g = 0; g < GP_COUNT; g++)
      if (gpHit[g] && !volSel) rdByte = gpReg[g];
    if (acrHit) rdByte = {volSel, shdnBit, nvBusy, 5'b00000};
  end

  assign shutdown = ~shdnBit | ~shdnPin;

endmodule

// File: rtl/pot_i2c_regbank.sv
module pot_i2c_regbank
  import pot_i2c_pkg::*;
#(
  parameter int NV_BUSY_CYCLES = 400,
  parameter int GP_COUNT       = 6,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] idPins,
  input  logic       shdnPin,
  output logic [6:0] wiper0,
  output logic [6:0] wiper1,
  output logic       shutdown
);

  ctrlStrobe_t    strobe;
  logic [7:0]     rdByte;
  logic           sclLevel;
  logic           nvBusy;
  logic [1:0][6:0] wiperBus;

  pot_i2c_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .idPins(idPins),
    .rdByte(rdByte), .sdaOe(sdaOe), .strobe(strobe), .sclLevel(sclLevel)
  );

  pot_reg_dp #(.NUM_CH(2), .GP_COUNT(GP_COUNT), .WIPER_W(7),
               .NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shdnPin(shdnPin),
    .rdByte(rdByte), .wiperOut(wiperBus), .shutdown(shutdown), .nvBusy(nvBusy)
  );

  assign wiper0 = wiperBus[0];
  assign wiper1 = wiperBus[1];

endmodule

// File: rtl/pot_i2c_regbank_chk.sv
module pot_i2c_regbank_chk #(
  parameter int NV_BUSY_CYCLES = 400
) (
  input logic       clk,
  input logic       rstN,
  input logic       shdnPin,
  input logic       shutdown,
  input logic       sdaOe,
  input logic       sclLevel,
  input logic       nvBusy,
  input logic       stopPulse,
  input logic [6:0] wiper0,
  input logic [6:0] wiper1
);

  localparam int RUN_W = $clog2(NV_BUSY_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (nvBusy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R8: a low pin always shuts down
  a_r8_pin_forces_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    !shdnPin |-> shutdown);

  // R3: the acknowledge pull starts only while SCL is low
  a_r3_pull_in_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLevel);

  // R9: busy starts only from a STOP
  a_r9_busy_from_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nvBusy) |-> $past(stopPulse));

  // R9: busy never lasts longer than the configured window
  a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(NV_BUSY_CYCLES));

  // R10: no wiper moves while busy
  a_r10_busy_freezes_wipers: assert property (@(posedge clk) disable iff (!rstN)
    $past(nvBusy) |-> ($stable(wiper0) && $stable(wiper1)));

endmodule

bind pot_i2c_regbank pot_i2c_regbank_chk #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .shdnPin(shdnPin), .shutdown(shutdown), .sdaOe(sdaOe),
  .sclLevel(sclLevel), .nvBusy(nvBusy), .stopPulse(strobe.stopSeen),
  .wiper0(wiper0), .wiper1(wiper1)
);

// File: tb/sim_pot_i2c_regbank.sv
module sim_pot_i2c_regbank;

  localparam int NV_CYC = 2000;
  localparam int Q      = 8;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] ID_W = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] ID_R = {4'b1010, PINS, 1'b1};

  // {address, data}, written with steering clear then read back
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h0015, 16'h017F, 16'h02A5,
                                         16'h073C, 16'h00A2, 16'h05FF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic shdnPin = 1'b1;
  logic sdaOe, shutdown, busSda;
  logic [6:0] wiper0, wiper1;
  int nChecks = 0, nFail = 0;
  logic [6:0] expIvr [2];

  always #5 clk = ~clk;
  assign busSda = sdaM & ~sdaOe;

  pot_i2c_regbank #(.NV_BUSY_CYCLES(NV_CYC)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda), .sdaOe(sdaOe),
    .idPins(PINS), .shdnPin(shdnPin), .wiper0(wiper0), .wiper1(wiper1),
    .shutdown(shutdown)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    waitClk(Q/2); sdaM = 1'b0; waitClk(Q/2);
    sclM = 1'b1; waitClk(Q); sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic clockBit(input logic drv, output logic smp);
    waitClk(Q/2); sdaM = drv; waitClk(Q/2);
    sclM = 1'b1; waitClk(Q/2); smp = busSda; waitClk(Q/2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic getByte(input logic masterAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~masterAck, s);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    busStart();
    sendByte(ID_W, acks[2]);
    sendByte(a, acks[1]);
    sendByte(d, acks[0]);
    busStop();
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    logic k;
    busStart();
    sendByte(ID_W, k);
    sendByte(a, k);
    busStart();
    sendByte(ID_R, k);
    getByte(1'b0, d);
    busStop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic [7:0] rd, rd2;
    logic ak;
    expIvr[0] = 7'd64; expIvr[1] = 7'd64;
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R1 reset state
    check("R1 wiper0", 8'(wiper0), 8'd64);
    check("R1 wiper1", 8'(wiper1), 8'd64);
    check("R1 shutdown", 8'(shutdown), 8'd0);
    check("R1 sdaOe", 8'(sdaOe), 8'd0);
    regRead(8'd8, rd);
    check("R1 R7 control reset", rd, 8'h40);

    // R2 wrong strap bits: no ack, no effect
    busStart();
    sendByte({4'b1010, 3'b000, 1'b0}, ak);
    check("R2 bad device byte ack", 8'(ak), 8'd0);
    sendByte(8'd0, ak);
    sendByte(8'h11, ak);
    check("R2 ignored data ack", 8'(ak), 8'd0);
    busStop();
    waitClk(4);
    check("R2 wiper0 untouched", 8'(wiper0), 8'd64);
    busStart();
    sendByte({4'b1011, PINS, 1'b0}, ak);
    check("R2 bad prefix ack", 8'(ak), 8'd0);
    busStop();

    // R4 R6 R3 table walk with steering clear
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, d, e;
      a = VEC[v][15:8]; d = VEC[v][7:0];
      e = (a < 2) ? {1'b0, d[6:0]} : d;
      regWrite(a, d, acks);
      check("R3 acks on write", 8'(acks), 8'h07);
      if (a < 2) expIvr[a[0]] = d[6:0];
      waitClk(NV_CYC + 20);
      regRead(a, rd);
      check(a < 2 ? "R4 readback" : "R6 gp readback", rd, e);
      check("R4 wiper0 follows", 8'(wiper0), 8'(expIvr[0]));
      check("R4 wiper1 follows", 8'(wiper1), 8'(expIvr[1]));
    end

    // R8 shutdown combination
    shdnPin = 1'b0; waitClk(2);
    check("R8 pin low", 8'(shutdown), 8'd1);
    shdnPin = 1'b1; waitClk(2);
    check("R8 pin high", 8'(shutdown), 8'd0);
    regWrite(8'd8, 8'h00, acks);
    check("R8 bit clear", 8'(shutdown), 8'd1);
    regRead(8'd8, rd);
    check("R7 bit6 clear reads back", rd, 8'h00);
    regWrite(8'd8, 8'h5F, acks);
    check("R8 bit set", 8'(shutdown), 8'd0);
    regRead(8'd8, rd);
    check("R7 low bits read zero", rd, 8'h40);

    // R5 steering set: wiper only, no busy
    regWrite(8'd8, 8'hC0, acks);
    regWrite(8'd0, 8'h33, acks);
    check("R5 wiper0 written", 8'(wiper0), 8'h33);
    regRead(8'd0, rd);
    check("R5 read returns wiper", rd, 8'h33);
    regRead(8'd8, rd);
    check("R5 R9 no busy for volatile write", rd, 8'hC0);
    // R6 general-purpose hidden with steering set
    regRead(8'd3, rd);
    check("R6 gp reads zero", rd, 8'h00);
    regWrite(8'd2, 8'h99, acks);
    check("R6 dropped write acked", 8'(acks), 8'h07);
    regWrite(8'd8, 8'h40, acks);
    regRead(8'd2, rd);
    check("R6 gp kept", rd, 8'hA5);
    regRead(8'd0, rd);
    check("R5 start-up value kept", rd, 8'(expIvr[0]));
    check("R5 wiper0 after steering clear", 8'(wiper0), 8'h33);

    // R9 R10 busy window
    regWrite(8'd1, 8'h10, acks);
    expIvr[1] = 7'h10;
    regRead(8'd8, rd);
    check("R9 busy bit set", rd, 8'h60);
    regWrite(8'd8, 8'hC0, acks);
    regWrite(8'd0, 8'h01, acks);
    check("R10 write acked while busy", 8'(acks), 8'h07);
    check("R10 wiper0 unchanged", 8'(wiper0), 8'h33);
    waitClk(NV_CYC + 20);
    regRead(8'd8, rd);
    check("R9 R10 busy clear, control unchanged", rd, 8'h40);
    regRead(8'd0, rd);
    check("R10 start-up value unchanged", rd, 8'(expIvr[0]));
    check("R9 wiper1 written", 8'(wiper1), 8'h10);

    // R11 no auto-increment
    busStart();
    sendByte(ID_W, ak); sendByte(8'd6, ak);
    sendByte(8'h12, ak); sendByte(8'h34, ak);
    busStop();
    waitClk(NV_CYC + 20);
    busStart();
    sendByte(ID_W, ak); sendByte(8'd6, ak);
    busStart();
    sendByte(ID_R, ak);
    getByte(1'b1, rd);
    getByte(1'b0, rd2);
    busStop();
    check("R11 last byte kept", rd, 8'h34);
    check("R11 repeat read same", rd2, 8'h34);
    regRead(8'd7, rd);
    check("R11 neighbour untouched", rd, 8'h3C);

    // R12 repeated start with wrong device byte
    busStart();
    sendByte(ID_W, ak); sendByte(8'd8, ak);
    busStart();
    sendByte({4'b1010, ~PINS, 1'b1}, ak);
    check("R12 restart rematches", 8'(ak), 8'd0);
    busStart();
    sendByte(ID_R, ak);
    check("R12 restart good id acked", 8'(ak), 8'd1);
    getByte(1'b0, rd);
    busStop();
    check("R12 latched address kept", rd, 8'h40);

    waitClk(10);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule